// File: doc/BRIEF.md
# Dual-Lane Shift-Mask-Add Interpolator

This block is a two-lane arithmetic helper attached to a simple processor register bus. Each lane owns a 32-bit accumulator, a 32-bit base and a 21-bit control word. A third base register serves a combined result. A lane selects an accumulator value. It shifts that value right, keeps a chosen bit range and may sign-extend what remains. It then adds its base to form the lane result. Software reads the results with a peek, which has no side effect, or with a pop. A pop returns the same value as a peek and, at the clock edge that ends the read, loads both accumulators with results. This lets one read step a sequence of table indices or pointers.

Two cross-lane multiplexers couple the lanes. One takes the other lane's accumulator as input and the other feeds the other lane's result back on a pop. A raw-add bypass lets a lane add its unprocessed input to its base. A two-bit field is ORed into the upper bits of a lane result only on the bus. The block holds no sequencing state: every read is answered combinationally in the cycle it is presented, and the only transitions are register loads at the clock edge, from a bus write or from a pop.

Top module: `interp_dual_lane`

## Requirements
- R1: After reset, all seven storage registers read 0. The peek and pop addresses of both lanes and of the full result also read 0.
- R2: Control bits 4:0 give a shift amount from 0 to 31. The selected input value is shifted right logically by that amount.
- R3: Control bits 9:5 give the low end and bits 14:10 the high end of the kept range, both inclusive. All other bits become 0. When the high end is below the low end, the processed value is 0.
- R4: When control bit 15 is set, the value kept by the mask is sign-extended from its high-end bit to 32 bits. This applies to the value added to the base and to the value used by the full result.
- R5: When control bit 18 is set, the lane result is its base plus the selected input value, unshifted and unmasked. The full result still uses the processed value.
- R6: When control bit 16 is set, the selected input is the other lane's accumulator. This holds whether or not bit 18 is set.
- R7: When control bit 17 is set, a pop loads this lane's accumulator with the other lane's result instead of its own.
- R8: Control bits 20:19 are ORed into bits 29:28 of a lane result read at that lane's peek or pop address. The value loaded into an accumulator by a pop does not contain them.
- R9: The full result is base 2 plus the processed values of lane 0 and lane 1. It never receives the bits of R8.
- R10: A peek leaves the accumulators unchanged. A pop read of any of the three pop addresses returns the same value as the matching peek. At the same edge it updates both accumulators from results formed before the edge. A bus write to an accumulator in that cycle takes priority for that accumulator.
- R11: The word address map is: 0x0 accumulator 0, 0x1 accumulator 1, 0x2 base 0, 0x3 base 1, 0x4 base 2, 0x5 control 0, 0x6 control 1, 0x8 peek lane 0, 0x9 peek lane 1, 0xA peek full, 0xC pop lane 0, 0xD pop lane 1, 0xE pop full. Storage registers are written at the clock edge and read back. Control reads back its low 21 bits with zeros above. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, register loads at the rising edge |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; with a pop address it updates the accumulators at the edge |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Combinational read data for rd_addr |

## Verification
The pop property assumes a pop is never combined with a write to an accumulator in the same cycle. That case follows the write-priority rule in R10 instead. The peek property assumes no write at all in that cycle. The bench drives a write and a read in separate cycles, so both hold throughout. Any 21-bit control word is legal, including ranges whose high end is below the low end. For that reason the table and the random phase use arbitrary control values rather than restricting them.

// File: rtl/interp_pkg.sv
`timescale 1ns/1ps
package interp_pkg;
    localparam int IP_DW     = 32;
    localparam int SH_W      = $clog2(IP_DW);
    localparam int CW        = 3 * SH_W + 6;
    localparam int REG_AW    = 4;
    localparam int FORCE_LSB = IP_DW - 4;

    // field order from bit CW-1 down to bit 0
    typedef struct packed {
        logic [1:0]      force_hi;
        logic            raw;
        logic            xres;
        logic            xin;
        logic            sgn;
        logic [SH_W-1:0] hi;
        logic [SH_W-1:0] lo;
        logic [SH_W-1:0] shamt;
    } lane_ctrl_t;

    typedef enum logic [REG_AW-1:0] {
        A_ACC0  = 4'h0,
        A_ACC1  = 4'h1,
        A_BASE0 = 4'h2,
        A_BASE1 = 4'h3,
        A_BASE2 = 4'h4,
        A_CTRL0 = 4'h5,
        A_CTRL1 = 4'h6,
        A_PEEK0 = 4'h8,
        A_PEEK1 = 4'h9,
        A_PEEKF = 4'hA,
        A_POP0  = 4'hC,
        A_POP1  = 4'hD,
        A_POPF  = 4'hE
    } reg_addr_e;
endpackage

// File: rtl/interp_lane.sv
`timescale 1ns/1ps
module interp_lane
    import interp_pkg::*;
(
    input  logic [IP_DW-1:0] acc_self,
    input  logic [IP_DW-1:0] acc_other,
    input  logic [IP_DW-1:0] base,
    input  logic [SH_W-1:0]  shamt,
    input  logic [SH_W-1:0]  lo,
    input  logic [SH_W-1:0]  hi,
    input  logic             sgn,
    input  logic             xin,
    input  logic             raw,
    output logic [IP_DW-1:0] proc_val,
    output logic [IP_DW-1:0] result
);
    localparam logic [SH_W-1:0] TOPBIT = SH_W'(IP_DW - 1);
    localparam logic [IP_DW-1:0] ONES  = '1;

    logic [IP_DW-1:0] src;
    logic [IP_DW-1:0] shifted;
    logic [IP_DW-1:0] keep;
    logic [IP_DW-1:0] kept;
    logic [IP_DW-1:0] upper;

    always_comb begin
        src      = xin ? acc_other : acc_self;
        shifted  = src >> shamt;
        keep     = (ONES << lo) & (ONES >> (TOPBIT - hi));
        kept     = shifted & keep;
        upper    = ~(ONES >> (TOPBIT - hi));
        proc_val = (sgn && kept[hi]) ? (kept | upper) : kept;
        result   = base + (raw ? src : proc_val);
    end
endmodule

// File: rtl/interp_rd_mux.sv
`timescale 1ns/1ps
module interp_rd_mux
    import interp_pkg::*;
(
    input  logic [REG_AW-1:0] addr,
    input  logic [IP_DW-1:0]  acc0,
    input  logic [IP_DW-1:0]  acc1,
    input  logic [IP_DW-1:0]  base0,
    input  logic [IP_DW-1:0]  base1,
    input  logic [IP_DW-1:0]  base2,
    input  lane_ctrl_t        ctrl0,
    input  lane_ctrl_t        ctrl1,
    input  logic [IP_DW-1:0]  res0,
    input  logic [IP_DW-1:0]  res1,
    input  logic [IP_DW-1:0]  full,
    output logic [IP_DW-1:0]  data
);
    logic [IP_DW-1:0] bus0;
    logic [IP_DW-1:0] bus1;

    always_comb begin
        bus0 = res0 | ({{(IP_DW-2){1'b0}}, ctrl0.force_hi} << FORCE_LSB);
        bus1 = res1 | ({{(IP_DW-2){1'b0}}, ctrl1.force_hi} << FORCE_LSB);
        case (addr)
            A_ACC0:           data = acc0;
            A_ACC1:           data = acc1;
            A_BASE0:          data = base0;
            A_BASE1:          data = base1;
            A_BASE2:          data = base2;
            A_CTRL0:          data = {{(IP_DW-CW){1'b0}}, ctrl0};
            A_CTRL1:          data = {{(IP_DW-CW){1'b0}}, ctrl1};
            A_PEEK0, A_POP0:  data = bus0;
            A_PEEK1, A_POP1:  data = bus1;
            A_PEEKF, A_POPF:  data = full;
            default:          data = '0;
        endcase
    end
endmodule

// File: rtl/interp_dual_lane.sv
`timescale 1ns/1ps
module interp_dual_lane
    import interp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [IP_DW-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [IP_DW-1:0]  rd_data
);
    localparam int NLANE = 2;

    logic [IP_DW-1:0] acc_q  [NLANE];
    logic [IP_DW-1:0] base_q [NLANE+1];
    lane_ctrl_t       ctrl_q [NLANE];
    logic [IP_DW-1:0] res_w  [NLANE];
    logic [IP_DW-1:0] proc_w [NLANE];
    logic [IP_DW-1:0] full_w;
    logic             pop_w;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        interp_lane u_lane (
            .acc_self (acc_q[g]),
            .acc_other(acc_q[NLANE-1-g]),
            .base     (base_q[g]),
            .shamt    (ctrl_q[g].shamt),
            .lo       (ctrl_q[g].lo),
            .hi       (ctrl_q[g].hi),
            .sgn      (ctrl_q[g].sgn),
            .xin      (ctrl_q[g].xin),
            .raw      (ctrl_q[g].raw),
            .proc_val (proc_w[g]),
            .result   (res_w[g])
        );
    end

    always_comb begin
        full_w = base_q[NLANE] + proc_w[0] + proc_w[1];
        pop_w  = rd_en && (rd_addr == A_POP0 || rd_addr == A_POP1 || rd_addr == A_POPF);
    end

    // register update: pop first, a same-cycle write then overrides
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLANE; i++) begin
                acc_q[i]  <= '0;
                ctrl_q[i] <= '0;
            end
            for (int i = 0; i <= NLANE; i++) begin
                base_q[i] <= '0;
            end
        end else begin
            if (pop_w) begin
                for (int i = 0; i < NLANE; i++) begin
                    acc_q[i] <= ctrl_q[i].xres ? res_w[NLANE-1-i] : res_w[i];
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    A_ACC0:  acc_q[0]  <= wr_data;
                    A_ACC1:  acc_q[1]  <= wr_data;
                    A_BASE0: base_q[0] <= wr_data;
                    A_BASE1: base_q[1] <= wr_data;
                    A_BASE2: base_q[2] <= wr_data;
                    A_CTRL0: ctrl_q[0] <= lane_ctrl_t'(wr_data[CW-1:0]);
                    A_CTRL1: ctrl_q[1] <= lane_ctrl_t'(wr_data[CW-1:0]);
                    default: ;
                endcase
            end
        end
    end

    interp_rd_mux u_rd_mux (
        .addr (rd_addr),
        .acc0 (acc_q[0]),
        .acc1 (acc_q[1]),
        .base0(base_q[0]),
        .base1(base_q[1]),
        .base2(base_q[2]),
        .ctrl0(ctrl_q[0]),
        .ctrl1(ctrl_q[1]),
        .res0 (res_w[0]),
        .res1 (res_w[1]),
        .full (full_w),
        .data (rd_data)
    );
endmodule

// File: rtl/interp_dual_lane_chk.sv
`timescale 1ns/1ps
module interp_dual_lane_chk
    import interp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [CW-1:0]     wr_low,
    input logic              rd_en,
    input logic [REG_AW-1:0] rd_addr,
    input logic [IP_DW-1:0]  rd_data,
    input logic [IP_DW-1:0]  acc0,
    input logic [IP_DW-1:0]  acc1,
    input logic [IP_DW-1:0]  res0,
    input logic [IP_DW-1:0]  res1,
    input lane_ctrl_t        ctrl0,
    input lane_ctrl_t        ctrl1
);
    logic is_pop;
    logic is_peek;
    assign is_pop  = rd_en && (rd_addr == A_POP0 || rd_addr == A_POP1 || rd_addr == A_POPF);
    assign is_peek = rd_en && (rd_addr == A_PEEK0 || rd_addr == A_PEEK1 || rd_addr == A_PEEKF);

    // R7
    pop_acc0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pop && !wr_en) |=> acc0 == $past(ctrl0.xres ? res1 : res0));

    // R7
    pop_acc1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pop && !wr_en) |=> acc1 == $past(ctrl1.xres ? res0 : res1));

    // R10
    peek_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_peek && !wr_en) |=> ($stable(acc0) && $stable(acc1)));

    // R8
    force_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_PEEK1) |-> ((rd_data[FORCE_LSB +: 2] & ctrl1.force_hi) == ctrl1.force_hi));

    // R11
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL0) |=> ctrl0 == $past(wr_low));
endmodule

bind interp_dual_lane interp_dual_lane_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_low (wr_data[interp_pkg::CW-1:0]),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .acc0   (acc_q[0]),
    .acc1   (acc_q[1]),
    .res0   (res_w[0]),
    .res1   (res_w[1]),
    .ctrl0  (ctrl_q[0]),
    .ctrl1  (ctrl_q[1])
);

// File: tb/interp_dual_lane_bench.sv
`timescale 1ns/1ps
module interp_dual_lane_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    interp_dual_lane u_interp_dual_lane (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // reference state
    logic [31:0] m_acc [2];
    logic [31:0] m_base [3];
    logic [31:0] m_ctrl [2];

    typedef struct packed {
        logic [31:0] c0; logic [31:0] c1;
        logic [31:0] a0; logic [31:0] a1;
        logic [31:0] b0; logic [31:0] b1; logic [31:0] b2;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1C04, 32'h0000_1448, 32'h1234_5678, 32'h0000_0FF0, 32'h0000_0100, 32'h0000_0200, 32'h0000_0010},
        '{32'h0000_9C00, 32'h0000_9C08, 32'h0000_0080, 32'h0000_7F00, 32'h0000_1000, 32'h0000_2000, 32'h0000_0000},
        '{32'h0005_1C00, 32'h0002_7C00, 32'h0000_0155, 32'hABCD_0123, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003},
        '{32'h0018_7C00, 32'h000A_7C00, 32'h0000_0040, 32'h0000_0004, 32'h0000_0100, 32'h0000_0200, 32'h0000_0300},
        '{32'h0000_8D20, 32'h0000_7C1F, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0055, 32'h0000_0066, 32'h0000_0077},
        '{32'h0002_7C00, 32'h0002_7C00, 32'h0000_0011, 32'h0000_0022, 32'h0000_0100, 32'h0000_1000, 32'h0000_0000}
    };

    function automatic logic [31:0] m_src(int i);
        return m_ctrl[i][16] ? m_acc[1-i] : m_acc[i];
    endfunction

    function automatic logic [31:0] m_proc(int i);
        logic [31:0] sh = m_src(i) >> m_ctrl[i][4:0];
        int lo = int'(m_ctrl[i][9:5]);
        int hi = int'(m_ctrl[i][14:10]);
        logic [31:0] v = '0;
        for (int b = 0; b < 32; b++)
            if (b >= lo && b <= hi) v[b] = sh[b];
        if (m_ctrl[i][15] && hi >= lo && v[hi])
            for (int b = 0; b < 32; b++)
                if (b > hi) v[b] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] m_res(int i);
        return m_base[i] + (m_ctrl[i][18] ? m_src(i) : m_proc(i));
    endfunction

    function automatic logic [31:0] m_bus(int i);
        return m_res(i) | {2'b00, m_ctrl[i][20:19], 28'h0};
    endfunction

    function automatic logic [31:0] m_full();
        return m_base[2] + m_proc(0) + m_proc(1);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        case (a)
            4'h0: m_acc[0] = d;
            4'h1: m_acc[1] = d;
            4'h2: m_base[0] = d;
            4'h3: m_base[1] = d;
            4'h4: m_base[2] = d;
            4'h5: m_ctrl[0] = {11'h0, d[20:0]};
            4'h6: m_ctrl[1] = {11'h0, d[20:0]};
            default: ;
        endcase
    endtask

    task automatic bus_rd(logic [3:0] a, output logic [31:0] got);
        logic [31:0] n0, n1;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 got = rd_data;
        n0 = m_ctrl[0][17] ? m_res(1) : m_res(0);
        n1 = m_ctrl[1][17] ? m_res(0) : m_res(1);
        @(posedge clk); #1;
        rd_en = 1'b0;
        if (a == 4'hC || a == 4'hD || a == 4'hE) begin
            m_acc[0] = n0;
            m_acc[1] = n1;
        end
    endtask

    task automatic load_all(vec_t v);
        bus_wr(4'h5, v.c0); bus_wr(4'h6, v.c1);
        bus_wr(4'h0, v.a0); bus_wr(4'h1, v.a1);
        bus_wr(4'h2, v.b0); bus_wr(4'h3, v.b1); bus_wr(4'h4, v.b2);
    endtask

    task automatic peek_pop_round(int k);
        logic [31:0] got, exp, e0, e1;
        bus_rd(4'h8, got); check("R2/R3/R4/R5/R6/R8 peek lane0", got, m_bus(0));
        bus_rd(4'h9, got); check("R2/R3/R4/R5/R6/R8 peek lane1", got, m_bus(1));
        bus_rd(4'hA, got); check("R9 peek full", got, m_full());
        case (k % 3)
            0: exp = m_bus(0);
            1: exp = m_bus(1);
            default: exp = m_full();
        endcase
        bus_rd(4'hC + 4'(k % 3), got); check("R10 pop value", got, exp);
        e0 = m_acc[0]; e1 = m_acc[1];
        bus_rd(4'h0, got); check("R7/R8/R10 acc0 after pop", got, e0);
        bus_rd(4'h1, got); check("R7/R8/R10 acc1 after pop", got, e1);
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] got;
        for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_ctrl[i] = '0; end
        for (int i = 0; i < 3; i++) m_base[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            if (a == 12 || a == 13 || a == 14) continue;
            bus_rd(4'(a), got); check("R1 reset read", got, 32'h0);
        end

        // R11 control readback width, unmapped address
        bus_wr(4'h5, 32'hFFFF_FFFF);
        bus_rd(4'h5, got); check("R11 ctrl0 readback", got, 32'h001F_FFFF);
        bus_wr(4'h7, 32'hDEAD_BEEF);
        bus_rd(4'h7, got); check("R11 unmapped read", got, 32'h0);
        bus_wr(4'h5, 32'h0);

        // table of vectors
        for (int k = 0; k < NV; k++) begin
            load_all(VECS[k]);
            peek_pop_round(k);
        end

        // R2 shift: acc0=0xF0, shift 4, keep 7:0 -> 0x0F
        load_all('{32'h0000_1C04, 32'h0, 32'h0000_00F0, 32'h0, 32'h0, 32'h0, 32'h0});
        bus_rd(4'h8, got); check("R2 shift by 4", got, 32'h0000_000F);
        // R3 inverted range gives 0 even when signed
        bus_wr(4'h5, 32'h0000_8D20);
        bus_rd(4'h8, got); check("R3 hi below lo", got, 32'h0);
        // R4 sign extension from bit 7
        bus_wr(4'h0, 32'h0000_0080); bus_wr(4'h5, 32'h0000_9C00);
        bus_rd(4'h8, got); check("R4 sign extend", got, 32'hFFFF_FF80);
        // R5 raw lane result, full still processed: shift 4 keep 3:0
        bus_wr(4'h0, 32'h0000_0123); bus_wr(4'h5, 32'h0004_0C04);
        bus_rd(4'h8, got); check("R5 raw lane result", got, 32'h0000_0123);
        bus_rd(4'hA, got); check("R5 full uses processed", got, 32'h0000_0002);
        // R6 cross input with raw: lane0 reads acc1
        bus_wr(4'h1, 32'h0000_0456); bus_wr(4'h5, 32'h0005_0000);
        bus_rd(4'h8, got); check("R6 cross input with raw", got, 32'h0000_0456);
        // R8 force bits on bus, not in accumulator
        bus_wr(4'h5, 32'h0018_7C00); bus_wr(4'h0, 32'h0000_0005);
        bus_rd(4'hC, got); check("R8 forced on pop", got, 32'h3000_0005);
        bus_rd(4'h0, got); check("R8 not fed back", got, 32'h0000_0005);
        // R10 peek repeat leaves accumulator
        bus_wr(4'h2, 32'h0000_0001);
        bus_rd(4'h8, got); bus_rd(4'h8, got);
        bus_rd(4'h0, got); check("R10 peek no side effect", got, 32'h0000_0005);

        // random control words
        for (int r = 0; r < 150; r++) begin
            vec_t v;
            v.c0 = {11'h0, 21'($urandom)}; v.c1 = {11'h0, 21'($urandom)};
            v.a0 = $urandom; v.a1 = $urandom;
            v.b0 = $urandom; v.b1 = $urandom; v.b2 = $urandom;
            load_all(v);
            peek_pop_round(r);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule